// File: doc/BRIEF.md
# Dual-Lane Shift-Or Byte Pattern Matcher

This block looks for one fixed byte string of length `PAT_LEN` in a byte stream that arrives two bytes per clock. Each clock a pair of bytes comes in under a valid strobe. Lane 0 carries the earlier byte and lane 1 the later one. The block raises a separate hit flag for each lane when the most recent `PAT_LEN` stream bytes, ending on that lane's byte, equal the pattern. A match can end on any byte position and still be found.

Inside, the pattern is cut into `ceil(PAT_LEN/2)` two-byte symbols. When the length is odd, the second byte of the final symbol is a wildcard. Two shift-or chains run in parallel:
- The first chain takes the pair exactly as it arrives.
- The second chain takes a pair made of the previous cycle's lane-1 byte and the current lane-0 byte.

Each byte position is covered by exactly one chain. Both chains read mismatch bits from the same pattern comparison function. The hit flags are combinational in the cycle the pair is presented, so a pattern sink can act on them before the next pair arrives.

Top module: `sor2_matcher`

## Requirements
- R1: While reset is asserted and at the first pair after reset, both hit flags are low. No hit can occur until at least `PAT_LEN` valid bytes have been presented after reset.
- R2: `hit_lane0` is high in a cycle with `in_valid` high exactly when the last `PAT_LEN` bytes ending at `in_lane0` equal the pattern. The stream order within a pair is `in_lane0` first, then `in_lane1`.
- R3: `hit_lane1` is high in a cycle with `in_valid` high exactly when the last `PAT_LEN` bytes ending at `in_lane1` equal the pattern.
- R4: For an odd `PAT_LEN`, matches ending on either lane are flagged in the cycle their final byte arrives. No later byte is awaited.
- R5: For an even `PAT_LEN`, matches ending on either lane are flagged in the cycle their final byte arrives.
- R6: Pattern byte k, counted from 1, sits at `PATTERN[8k-1:8k-8]`. A stream holding the pattern in reverse order produces no hit.
- R7: In a cycle with `in_valid` low, both hit flags are low and the lane values are ignored. The stream continues across the stall as if the idle cycle were absent.
- R8: Bytes presented before the most recent reset never contribute to a match.
- R9: Overlapping occurrences of the pattern are each flagged at their own final byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies the byte pair in this cycle |
| in_lane0 | input | 8 | Earlier byte of the pair |
| in_lane1 | input | 8 | Later byte of the pair |
| hit_lane0 | output | 1 | Pattern ends at `in_lane0` this cycle |
| hit_lane1 | output | 1 | Pattern ends at `in_lane1` this cycle |

## Verification
A corrupted flip-flop in either chain shows up as a missed or spurious hit. The error appears on the lane that chain serves, at most `ceil(PAT_LEN/2)` valid pairs later. Once it has shifted past the last stage, it has no further effect. A wrong held previous byte, or a wrong priming flag, shows up on the second chain's lane: the next time the pattern straddles the pair boundary, the match is lost or invented. Comparing both lanes on every valid pair, for an odd and an even pattern length, against a byte-serial model therefore exposes a fault within a few pairs of its cause.

// File: rtl/sor2_pkg.sv
package sor2_pkg;

  typedef logic [7:0] byte_t;

  // One shift-or cell: a prefix survives only if the upstream prefix
  // survived and this symbol compares equal (0 means "still matching").
  function automatic logic or_stage(logic upstream, logic miss);
    return upstream | miss;
  endfunction

endpackage

// File: rtl/sor2_chain.sv
module sor2_chain
  import sor2_pkg::*;
#(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         seed,
  input  logic [N-1:0] miss,
  output logic         hit
);

  // nxt[k] is the prefix state after consuming the current symbol
  logic [N-1:0] nxt;

  generate
    if (N == 1) begin : g_single
      assign nxt[0] = or_stage(seed, miss[0]);
    end else begin : g_multi
      logic [N-2:0] st_q;

      assign nxt[0] = or_stage(seed, miss[0]);
      for (genvar k = 1; k < N; k++) begin : g_stage
        assign nxt[k] = or_stage(st_q[k-1], miss[k]);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  st_q <= '1;
        else if (en) st_q <= nxt[N-2:0];
      end
    end
  endgenerate

  assign hit = ~nxt[N-1];

endmodule

// File: rtl/sor2_pairgen.sv
module sor2_pairgen
  import sor2_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  byte_t late_byte,
  output byte_t prev_q,
  output logic  primed_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else if (en) begin
      prev_q   <= late_byte;
      primed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/sor2_matcher.sv
module sor2_matcher
  import sor2_pkg::*;
#(
  parameter int               PAT_LEN = 5,
  parameter logic [8*PAT_LEN-1:0] PATTERN = 40'h63_61_62_61_61
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_lane0,
  input  logic [7:0] in_lane1,
  output logic       hit_lane0,
  output logic       hit_lane1
);

  localparam int  NSYM   = (PAT_LEN + 1) / 2;
  localparam bit  ODD    = (PAT_LEN % 2) == 1;
  localparam int  NB     = ODD ? NSYM - 1 : NSYM;

  generate
    if (PAT_LEN < 2) begin : g_bad_len
      $error("sor2_matcher: PAT_LEN must be at least 2");
    end
  endgenerate

  // pattern byte idx (0-based, first pattern byte at idx 0)
  function automatic byte_t pat_byte(int idx);
    return PATTERN[8*idx +: 8];
  endfunction

  // mismatch bit of pair symbol i (0-based) against the pair (b0,b1);
  // the wildcard second byte of an odd-length tail is never compared
  function automatic logic miss_bit(int i, byte_t b0, byte_t b1);
    logic m0;
    m0 = (b0 != pat_byte(2*i));
    if (ODD && i == NSYM - 1) return m0;
    return m0 | (b1 != pat_byte(2*i + 1));
  endfunction

  // previous lane-1 byte, priming flag
  byte_t prev_byte;
  logic  primed;

  sor2_pairgen u_pairgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (in_valid),
    .late_byte(in_lane1),
    .prev_q   (prev_byte),
    .primed_q (primed)
  );

  // aligned chain: pair (lane0, lane1)
  logic [NSYM-1:0] miss_a;
  logic            hit_a;

  // straddling chain: pair (previous lane1, lane0)
  logic [NB-1:0]   miss_b;
  logic            hit_b;
  logic            seed_b;

  generate
    for (genvar i = 0; i < NSYM; i++) begin : g_miss_a
      assign miss_a[i] = miss_bit(i, in_lane0, in_lane1);
    end
    for (genvar i = 0; i < NB; i++) begin : g_miss_b
      assign miss_b[i] = miss_bit(i, prev_byte, in_lane0);
    end
  endgenerate

  // until one byte is held, the straddling chain sees no starting prefix
  assign seed_b = ~primed;

  sor2_chain #(.N(NSYM)) u_chain_a (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_valid),
    .seed (1'b0),
    .miss (miss_a),
    .hit  (hit_a)
  );

  sor2_chain #(.N(NB)) u_chain_b (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (in_valid),
    .seed (seed_b),
    .miss (miss_b),
    .hit  (hit_b)
  );

  generate
    if (ODD) begin : g_odd_out
      // the straddling chain's tail is a half pair: only lane1 remains
      logic tail_eq;
      assign tail_eq   = (in_lane1 == pat_byte(PAT_LEN - 1));
      assign hit_lane0 = in_valid & hit_a;
      assign hit_lane1 = in_valid & hit_b & tail_eq;
    end else begin : g_even_out
      assign hit_lane0 = in_valid & hit_b;
      assign hit_lane1 = in_valid & hit_a;
    end
  endgenerate

endmodule

// File: rtl/sor2_matcher_chk.sv
module sor2_matcher_chk #(
  parameter int                   PAT_LEN = 5,
  parameter logic [8*PAT_LEN-1:0] PATTERN = 40'h63_61_62_61_61
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_lane0,
  input logic [7:0] in_lane1,
  input logic       hit_lane0,
  input logic       hit_lane1,
  input logic [7:0] prev_byte,
  input logic       primed
);

  localparam bit         ODD  = (PAT_LEN % 2) == 1;
  localparam logic [7:0] LASTB = PATTERN[8*(PAT_LEN-1) +: 8];
  localparam logic [7:0] PENB  = PATTERN[8*(PAT_LEN-2) +: 8];

  AST_NO_HIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!hit_lane0 && !hit_lane1)); // R7

  AST_LANE0_END: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lane0 |-> (in_lane0 == LASTB)); // R2

  AST_LANE1_END: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lane1 |-> (in_lane1 == LASTB)); // R3

  AST_LANE0_PREV: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lane0 |-> (primed && prev_byte == PENB)); // R2

  AST_LANE1_PEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lane1 |-> (in_lane0 == PENB)); // R3

  AST_PRIME_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !(ODD ? hit_lane1 : hit_lane0)); // R8

  AST_PREV_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (prev_byte == $past(in_lane1))); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(prev_byte)); // R7

endmodule

bind sor2_matcher sor2_matcher_chk #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_lane0 (in_lane0),
  .in_lane1 (in_lane1),
  .hit_lane0(hit_lane0),
  .hit_lane1(hit_lane1),
  .prev_byte(prev_byte),
  .primed   (primed)
);

// File: tb/test_sor2_matcher.sv
module test_sor2_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int M_ODD  = 5;
  localparam int M_EVEN = 4;
  // first pattern byte in the low byte: "aabac" and "abaa"
  localparam logic [8*M_ODD-1:0]  PAT_ODD  = 40'h63_61_62_61_61;
  localparam logic [8*M_EVEN-1:0] PAT_EVEN = 32'h61_61_62_61;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_lane0 = 8'h0;
  logic [7:0] in_lane1 = 8'h0;
  logic       ho0, ho1, he0, he1;

  int total = 0;
  int bad   = 0;
  logic [7:0] hist [8];
  int nbytes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sor2_matcher #(.PAT_LEN(M_ODD), .PATTERN(PAT_ODD)) i_sor2_matcher (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_lane0(in_lane0), .in_lane1(in_lane1),
    .hit_lane0(ho0), .hit_lane1(ho1)
  );

  sor2_matcher #(.PAT_LEN(M_EVEN), .PATTERN(PAT_EVEN)) i_sor2_matcher_even (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_lane0(in_lane0), .in_lane1(in_lane1),
    .hit_lane0(he0), .hit_lane1(he1)
  );

  // byte-serial reference: hist[0] is the newest byte
  task automatic push(input logic [7:0] b);
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = b;
    nbytes++;
  endtask

  function automatic logic ref_match(int m, logic [39:0] pat);
    if (nbytes < m) return 1'b0;
    for (int k = 0; k < m; k++)
      if (hist[k] != pat[8*(m-1-k) +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check_bit(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [7:0] l0, input logic [7:0] l1);
    logic eo0, eo1, ee0, ee1;
    @(negedge clk);
    in_valid = v; in_lane0 = l0; in_lane1 = l1;
    eo0 = 0; eo1 = 0; ee0 = 0; ee1 = 0;
    if (v) begin
      push(l0);
      eo0 = ref_match(M_ODD, PAT_ODD);
      ee0 = ref_match(M_EVEN, {8'h0, PAT_EVEN});
      push(l1);
      eo1 = ref_match(M_ODD, PAT_ODD);
      ee1 = ref_match(M_EVEN, {8'h0, PAT_EVEN});
    end
    #1;
    check_bit({"R2 R4 odd lane0 ", tag}, ho0, eo0);
    check_bit({"R3 R4 odd lane1 ", tag}, ho1, eo1);
    check_bit({"R2 R5 even lane0 ", tag}, he0, ee0);
    check_bit({"R3 R5 even lane1 ", tag}, he1, ee1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      #1;
      check_bit("R1 reset lane0", ho0 | he0, 1'b0);
      check_bit("R1 reset lane1", ho1 | he1, 1'b0);
    end
    nbytes = 0;
    for (int k = 0; k < 8; k++) hist[k] = 8'h0;
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] rand_byte();
    int r;
    r = $urandom % 10;
    if (r < 5) return 8'h61;
    if (r < 7) return 8'h62;
    if (r < 9) return 8'h63;
    return 8'($urandom);
  endfunction

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    do_reset();
    // R1: first pair after reset cannot hit
    step("R1 first pair", 1'b1, 8'h61, 8'h61);

    // R4 R6: "aabac" ending on lane0
    do_reset();
    step("R6 a", 1'b1, 8'h61, 8'h61);
    step("R6 b", 1'b1, 8'h62, 8'h61);
    step("R6 c", 1'b1, 8'h63, 8'h7a);
    // R4 R9 shifted by one: ends on lane1, next byte arbitrary
    do_reset();
    step("R9 s0", 1'b1, 8'h7a, 8'h61);
    step("R9 s1", 1'b1, 8'h61, 8'h62);
    step("R9 s2", 1'b1, 8'h61, 8'h63);
    step("R9 s3", 1'b1, 8'hff, 8'h00);
    // R6: reversed pattern "cabaa" gives no hit
    do_reset();
    step("R6 rev0", 1'b1, 8'h63, 8'h61);
    step("R6 rev1", 1'b1, 8'h62, 8'h61);
    step("R6 rev2", 1'b1, 8'h61, 8'h7a);
    // R9: overlapping "abaabaa" for the even pattern
    do_reset();
    step("R9 ov0", 1'b1, 8'h61, 8'h62);
    step("R9 ov1", 1'b1, 8'h61, 8'h61);
    step("R9 ov2", 1'b1, 8'h62, 8'h61);
    step("R9 ov3", 1'b1, 8'h61, 8'h62);
    // R7: stalls with garbage inside a match
    do_reset();
    step("R7 p0", 1'b1, 8'h61, 8'h61);
    step("R7 idle", 1'b0, 8'h63, 8'h63);
    step("R7 idle", 1'b0, 8'h61, 8'h61);
    step("R7 p1", 1'b1, 8'h62, 8'h61);
    step("R7 idle", 1'b0, 8'h62, 8'h61);
    step("R7 p2", 1'b1, 8'h63, 8'h62);
    // R8: prefix before reset must not complete a match after it
    step("R8 pre0", 1'b1, 8'h61, 8'h61);
    step("R8 pre1", 1'b1, 8'h62, 8'h61);
    do_reset();
    step("R8 post", 1'b1, 8'h63, 8'h61);
    step("R8 post", 1'b1, 8'h61, 8'h61);

    // random traffic with stalls
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      if (n == 2000) do_reset();
      step("rand", ($urandom % 5) != 0, rand_byte(), rand_byte());
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule